// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block sits between a processor data port and a register file whose registers do not all share one width. The processor may issue byte, halfword or word accesses to any register. Each register, however, only understands accesses of its own native width of one, two or four bytes. The adapter finds the native width of the addressed 4-byte group in a width map. It then turns the processor access into one or more register-side sub-accesses that all carry that native width.

A wide processor access to narrow registers is cut into several native accesses in big-endian order, with the most significant part at the lowest address. A narrow read of a wide register fetches the whole native unit and selects the addressed lanes. A narrow write to a wide register becomes a read, a lane merge and a write back. A small sequencer runs every multi-step case and returns one completion pulse to the processor when the last sub-access is done. Addresses outside the implemented window, and groups the map marks as empty, finish at once with an error flag.

Data on both sides is right-aligned. A byte sits in bits 7:0, a halfword in bits 15:0, and unused upper read bits are zero. The register file answers a read in the same cycle as the request. Size encoding on both sides: 0 is one byte, 1 is two bytes, 2 is four bytes. A processor size of 3 is treated as four bytes.

Top module: `span_adapter`

## Requirements
- R1: Only the low 10 bits of the processor address form the offset; higher address bits are ignored. Any offset from 0x200 to 0x3FF completes with `cpu_err` high.
- R2: The native width comes from offset bits 6:5 (group index bits 4:3): 0 gives one byte, 1 gives two bytes, 2 gives four bytes, 3 marks an empty group. An access to an empty group or an out-of-range offset completes with `cpu_err`=1 and `cpu_rdata`=0, and it makes no register-side access. A write to such a group is dropped.
- R3: When the access size equals the native width, exactly one register-side access of that size is made at the access offset.
- R4: A byte read of a two-byte register reads the halfword at the even address. It returns bits 15:8 for an even offset and bits 7:0 for an odd offset.
- R5: A halfword read of a four-byte register reads the aligned word. It returns bits 31:16 when offset bit 1 is 0, and bits 15:0 otherwise.
- R6: A byte read of a four-byte register reads the aligned word. It returns the byte whose lane is offset bits 1:0, where lane 0 is bits 31:24.
- R7: A halfword access to one-byte registers becomes two byte accesses. The first is at the offset and carries bits 15:8; the second is at offset+1 and carries bits 7:0.
- R8: A word access to two-byte registers becomes two halfword accesses, at the offset and at offset+2. A word access to one-byte registers becomes four byte accesses at ascending addresses. In both cases the lowest address carries the most significant part.
- R9: A write narrower than the native width first reads the native unit. It then writes the unit back with only the addressed lanes replaced. The other lanes keep their values.
- R10: `cpu_ready` is a one-cycle pulse. For a valid access it comes only after the final sub-access, and `cpu_rdata` and `cpu_err` are valid in that same cycle.
- R11: Offset bits below the access size are ignored, so each access is naturally aligned. Size code 3 behaves as a word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_size | input | 2 | Access size code |
| cpu_addr | input | ADDR_W | Byte address; low 10 bits used |
| cpu_wdata | input | 32 | Right-aligned write data |
| cpu_ready | output | 1 | Completion pulse |
| cpu_err | output | 1 | Error flag, valid with `cpu_ready` |
| cpu_rdata | output | 32 | Right-aligned read data, valid with `cpu_ready` |
| reg_req | output | 1 | Register-side sub-access strobe |
| reg_we | output | 1 | Sub-access is a write |
| reg_size | output | 2 | Native size code of the sub-access |
| reg_addr | output | SPAN_W | Native-aligned register offset |
| reg_wdata | output | 32 | Right-aligned sub-access write data |
| reg_rdata | input | 32 | Right-aligned register read data, same cycle |

## Verification
The accesses cover every pairing of access size and native width: equal sizes, two- and four-way splits, lane selects at each byte and half position, and read-modify-write in both byte-in-half and half-in-word form. The bench models the register file as a big-endian byte array. Each result must therefore match the plain byte view of memory whatever the native width, and a swapped lane order or wrong lane select shows up as a data miscompare. The bench also logs the count, order, size and direction of the register-side sub-accesses, which tells split ordering and read-before-write apart from a merely correct final value. Empty groups, out-of-range offsets, masked upper address bits and misaligned or size-3 accesses each get their own case.

// File: rtl/span_pkg.sv
// Package: shared state type and small lookup helpers for the width adapter.
// Assumes a 32-bit data path with right-aligned data on both sides.
package span_pkg;

    localparam int unsigned DATA_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SPLIT = 3'd1,
        ST_FETCH = 3'd2,
        ST_PUT   = 3'd3,
        ST_DONE  = 3'd4
    } seq_st_t;

    // Width code from group index bits 4:3: 0 empty, 1 byte, 2 half, 3 word.
    function automatic logic [1:0] width_code(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2'd1;
            2'd1:    return 2'd2;
            2'd2:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    // Address mask covering the bytes inside a unit of 2**lg bytes.
    function automatic logic [1:0] low_mask(input logic [1:0] lg);
        case (lg)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    // Data mask for a right-aligned unit of 2**lg bytes.
    function automatic logic [DATA_W-1:0] data_mask(input logic [1:0] lg);
        case (lg)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/span_decode.sv
// Module: span_decode
// Classifies a processor access: range check, native width lookup, aligned
// base address, lane offset and split count. Purely combinational.
// Assumes SPAN_W >= 7 so that the width-map select bits exist.
module span_decode
    import span_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SPAN_W = 10,
    parameter int LIMIT  = 512
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    output logic              dec_err,
    output logic [1:0]        dec_cs,
    output logic [1:0]        dec_ns,
    output logic              dec_narrow,
    output logic [SPAN_W-1:0] dec_base,
    output logic [1:0]        dec_off,
    output logic [1:0]        dec_last
);
    localparam logic [SPAN_W:0] LIM = LIMIT[SPAN_W:0];
    localparam int PADW = SPAN_W - 2;

    logic [SPAN_W-1:0] off, aligned, cs_mask, ns_mask;
    logic [1:0]        wcode;
    logic [1:0]        ratio;

    // Decode offset, sizes and the sub-access plan for the incoming access.
    always_comb begin
        off     = cpu_addr[SPAN_W-1:0];
        dec_cs  = (cpu_size == 2'd3) ? 2'd2 : cpu_size;
        cs_mask = {{PADW{1'b0}}, low_mask(dec_cs)};
        aligned = off & ~cs_mask;
        wcode   = width_code(off[6:5]);
        dec_err = ({1'b0, off} >= LIM) || (wcode == 2'd0);
        dec_ns  = (wcode == 2'd0) ? 2'd0 : (wcode - 2'd1);
        ns_mask = {{PADW{1'b0}}, low_mask(dec_ns)};
        dec_narrow = (dec_cs < dec_ns);
        dec_base   = dec_narrow ? (off & ~ns_mask) : aligned;
        dec_off    = dec_narrow ? (aligned[1:0] & ns_mask[1:0]) : 2'd0;
        ratio      = dec_cs - dec_ns;
        if (dec_narrow) begin
            dec_last = 2'd0;
        end else begin
            case (ratio)
                2'd0:    dec_last = 2'd0;
                2'd1:    dec_last = 2'd1;
                default: dec_last = 2'd3;
            endcase
        end
    end

endmodule

// File: rtl/span_lanes.sv
// Module: span_lanes
// Big-endian lane selector and merger for a narrow access inside a wider
// native unit. Lane 0 is the most significant byte of the unit.
// Assumes cs < ns whenever its outputs are used.
module span_lanes
    import span_pkg::*;
(
    input  logic [DATA_W-1:0] nat_data,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic [1:0]        lane_off,
    input  logic [1:0]        cs,
    input  logic [1:0]        ns,
    output logic [DATA_W-1:0] pick,
    output logic [DATA_W-1:0] merged
);
    logic [2:0]        nb, cb, pos;
    logic [5:0]        sh;
    logic [DATA_W-1:0] m;

    // Compute the bit position of the addressed lanes, then select or replace them.
    always_comb begin
        nb     = 3'd1 << ns;
        cb     = 3'd1 << cs;
        pos    = nb - {1'b0, lane_off} - cb;
        sh     = {pos, 3'b000};
        m      = data_mask(cs) << sh;
        pick   = (nat_data >> sh) & data_mask(cs);
        merged = (nat_data & ~m) | ((cpu_data & data_mask(cs)) << sh);
    end

endmodule

// File: rtl/span_seq.sv
// Module: span_seq
// Sequencer that issues the native sub-accesses of one processor access:
// a run of split accesses, or a fetch followed by an optional write back.
// Assumes the register file returns read data in the request cycle and
// that cpu_req stays high until cpu_ready.
module span_seq
    import span_pkg::*;
#(
    parameter int SPAN_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              dec_err,
    input  logic [1:0]        dec_cs,
    input  logic [1:0]        dec_ns,
    input  logic              dec_narrow,
    input  logic [SPAN_W-1:0] dec_base,
    input  logic [1:0]        dec_off,
    input  logic [1:0]        dec_last,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] lane_pick,
    input  logic [DATA_W-1:0] lane_merged,
    output logic [1:0]        lane_off_q,
    output logic [1:0]        cs_q,
    output logic [1:0]        ns_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              reg_req,
    output logic              reg_we,
    output logic [1:0]        reg_size,
    output logic [SPAN_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              cpu_ready,
    output logic              cpu_err,
    output logic [DATA_W-1:0] cpu_rdata
);
    localparam int PADW = SPAN_W - 2;

    seq_st_t           st;
    logic              we_q, err_q;
    logic [SPAN_W-1:0] base_q;
    logic [1:0]        idx_q, last_q, diff;
    logic [DATA_W-1:0] acc_q, rdata_q, nat, acc_next;
    logic [5:0]        piece_sh;

    // Accumulate split read data and pick the write piece for the current step.
    always_comb begin
        nat = reg_rdata & data_mask(ns_q);
        case (ns_q)
            2'd0:    acc_next = {acc_q[23:0], nat[7:0]};
            2'd1:    acc_next = {acc_q[15:0], nat[15:0]};
            default: acc_next = nat;
        endcase
        diff = last_q - idx_q;
        case (ns_q)
            2'd0:    piece_sh = {1'b0, diff, 3'b000};
            2'd1:    piece_sh = {diff, 4'b0000};
            default: piece_sh = 6'd0;
        endcase
    end

    // Drive the register-side sub-access for the current state.
    always_comb begin
        reg_req   = (st == ST_SPLIT) || (st == ST_FETCH) || (st == ST_PUT);
        reg_we    = ((st == ST_SPLIT) && we_q) || (st == ST_PUT);
        reg_size  = ns_q;
        reg_addr  = base_q;
        reg_wdata = '0;
        if (st == ST_SPLIT) begin
            reg_addr  = base_q + ({{PADW{1'b0}}, idx_q} << ns_q);
            reg_wdata = (wdata_q >> piece_sh) & data_mask(ns_q);
        end else if (st == ST_PUT) begin
            reg_wdata = acc_q;
        end
    end

    // Step the access through accept, sub-accesses and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            we_q       <= 1'b0;
            err_q      <= 1'b0;
            base_q     <= '0;
            idx_q      <= 2'd0;
            last_q     <= 2'd0;
            cs_q       <= 2'd0;
            ns_q       <= 2'd0;
            lane_off_q <= 2'd0;
            wdata_q    <= '0;
            acc_q      <= '0;
            rdata_q    <= '0;
        end else begin
            case (st)
                ST_IDLE: if (cpu_req) begin
                    we_q       <= cpu_we;
                    wdata_q    <= cpu_wdata;
                    cs_q       <= dec_cs;
                    ns_q       <= dec_ns;
                    base_q     <= dec_base;
                    lane_off_q <= dec_off;
                    last_q     <= dec_last;
                    idx_q      <= 2'd0;
                    acc_q      <= '0;
                    rdata_q    <= '0;
                    err_q      <= dec_err;
                    if (dec_err)         st <= ST_DONE;
                    else if (dec_narrow) st <= ST_FETCH;
                    else                 st <= ST_SPLIT;
                end
                ST_SPLIT: begin
                    acc_q <= acc_next;
                    if (idx_q == last_q) begin
                        rdata_q <= we_q ? '0 : acc_next;
                        st      <= ST_DONE;
                    end else begin
                        idx_q <= idx_q + 2'd1;
                    end
                end
                ST_FETCH: begin
                    if (we_q) begin
                        acc_q <= lane_merged;
                        st    <= ST_PUT;
                    end else begin
                        rdata_q <= lane_pick;
                        st      <= ST_DONE;
                    end
                end
                ST_PUT:  st <= ST_DONE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready = (st == ST_DONE);
    assign cpu_err   = err_q;
    assign cpu_rdata = rdata_q;

    // R10: completion is a single-cycle pulse.
    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R2: an error completion follows no register-side access.
    assert_err_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_err) |-> !$past(reg_req));

    // R2: an error completion returns zero data.
    assert_err_zero_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_err) |-> (cpu_rdata == '0));

    // R9: a write-back is always preceded by a read of the same unit.
    assert_rmw_read_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && $past(reg_req) && !$past(reg_we) && (st == ST_PUT))
            |-> ($past(reg_addr) == reg_addr));

endmodule

// File: rtl/span_adapter.sv
// Module: span_adapter (top)
// Adapts byte, halfword and word processor accesses to registers of mixed
// native width, splitting or merging in big-endian order.
// Assumes a register file with same-cycle read data and a requester that
// holds cpu_req and its fields until cpu_ready.
module span_adapter
    import span_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SPAN_W = 10,
    parameter int LIMIT  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_err,
    output logic [31:0]       cpu_rdata,
    output logic              reg_req,
    output logic              reg_we,
    output logic [1:0]        reg_size,
    output logic [SPAN_W-1:0] reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata
);
    logic              dec_err, dec_narrow;
    logic [1:0]        dec_cs, dec_ns, dec_off, dec_last;
    logic [SPAN_W-1:0] dec_base;
    logic [1:0]        lane_off_q, cs_q, ns_q;
    logic [DATA_W-1:0] wdata_q, lane_pick, lane_merged;

    span_decode #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W), .LIMIT(LIMIT)) decode_i (
        .cpu_addr   (cpu_addr),
        .cpu_size   (cpu_size),
        .dec_err    (dec_err),
        .dec_cs     (dec_cs),
        .dec_ns     (dec_ns),
        .dec_narrow (dec_narrow),
        .dec_base   (dec_base),
        .dec_off    (dec_off),
        .dec_last   (dec_last)
    );

    span_lanes lanes_i (
        .nat_data (reg_rdata),
        .cpu_data (wdata_q),
        .lane_off (lane_off_q),
        .cs       (cs_q),
        .ns       (ns_q),
        .pick     (lane_pick),
        .merged   (lane_merged)
    );

    span_seq #(.SPAN_W(SPAN_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_wdata   (cpu_wdata),
        .dec_err     (dec_err),
        .dec_cs      (dec_cs),
        .dec_ns      (dec_ns),
        .dec_narrow  (dec_narrow),
        .dec_base    (dec_base),
        .dec_off     (dec_off),
        .dec_last    (dec_last),
        .reg_rdata   (reg_rdata),
        .lane_pick   (lane_pick),
        .lane_merged (lane_merged),
        .lane_off_q  (lane_off_q),
        .cs_q        (cs_q),
        .ns_q        (ns_q),
        .wdata_q     (wdata_q),
        .reg_req     (reg_req),
        .reg_we      (reg_we),
        .reg_size    (reg_size),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .cpu_ready   (cpu_ready),
        .cpu_err     (cpu_err),
        .cpu_rdata   (cpu_rdata)
    );

    localparam logic [SPAN_W:0] LIM = LIMIT[SPAN_W:0];

    // R1: no sub-access ever leaves the implemented window.
    assert_addr_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> ({1'b0, reg_addr} < LIM));

    // R2: every sub-access carries the native width of its group.
    assert_native_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> (({1'b0, reg_size} + 3'd1) == {1'b0, width_code(reg_addr[6:5])}));

    // R3: sub-accesses are aligned to their own size.
    assert_native_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> ((reg_addr[1:0] & low_mask(reg_size)) == 2'd0));

    // R10: a good completion comes right after the final sub-access.
    assert_ready_after_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_err) |-> $past(reg_req));

endmodule

// File: tb/span_adapter_tb.sv
// Scoreboard bench: the driver pushes expected results computed from a
// big-endian byte shadow of the register file; the monitor compares them on
// each completion pulse and logs register-side sub-accesses.
module span_adapter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [11:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready, cpu_err;
    logic [31:0] cpu_rdata;
    logic        reg_req, reg_we;
    logic [1:0]  reg_size;
    logic [9:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;   // 250 MHz

    span_adapter dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
        .reg_req(reg_req), .reg_we(reg_we), .reg_size(reg_size),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Register file model: big-endian byte array, same-cycle read data.
    logic [7:0] rf [0:511];
    logic [7:0] shadow [0:511];
    logic [8:0] ra;
    assign ra = reg_addr[8:0];
    assign reg_rdata = (reg_size == 2'd0) ? {24'd0, rf[ra]} :
                       (reg_size == 2'd1) ? {16'd0, rf[ra], rf[ra + 9'd1]} :
                       {rf[ra], rf[ra + 9'd1], rf[ra + 9'd2], rf[ra + 9'd3]};

    always @(posedge clk) begin
        if (rst_n && reg_req && reg_we) begin
            case (reg_size)
                2'd0: rf[ra] <= reg_wdata[7:0];
                2'd1: begin rf[ra] <= reg_wdata[15:8]; rf[ra + 9'd1] <= reg_wdata[7:0]; end
                default: begin
                    rf[ra]        <= reg_wdata[31:24];
                    rf[ra + 9'd1] <= reg_wdata[23:16];
                    rf[ra + 9'd2] <= reg_wdata[15:8];
                    rf[ra + 9'd3] <= reg_wdata[7:0];
                end
            endcase
        end
    end

    // Scoreboard queues and sub-access log.
    logic [31:0] exp_d[$];
    logic        exp_e[$];
    string       exp_tag[$];
    int          sub_n = 0;
    int          sub_addr [0:7];
    int          sub_sz   [0:7];
    logic        sub_we   [0:7];

    // Monitor: log sub-accesses and compare each completion.
    always @(negedge clk) begin
        if (rst_n && reg_req && sub_n < 8) begin
            sub_addr[sub_n] = int'(reg_addr);
            sub_sz[sub_n]   = 1 << reg_size;
            sub_we[sub_n]   = reg_we;
            sub_n++;
        end
        if (rst_n && cpu_ready) begin
            logic [31:0] d; logic e; string t;
            if (exp_d.size() == 0) begin
                vectors++; miscompares++;
                $display("FAIL unexpected completion: actual rdata=%h expected none", cpu_rdata);
            end else begin
                d = exp_d.pop_front(); e = exp_e.pop_front(); t = exp_tag.pop_front();
                vectors++;
                if (cpu_rdata !== d || cpu_err !== e) begin
                    miscompares++;
                    $display("FAIL %s result: actual rdata=%h err=%b expected rdata=%h err=%b",
                             t, cpu_rdata, cpu_err, d, e);
                end
            end
        end
    end

    // Native width in bytes of an offset, from the requirement map (R2).
    function automatic int map_width(input int off);
        if (off >= 512) return 0;
        case ((off >> 5) & 3)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 0;
        endcase
    endfunction

    // Driver: compute expectations, issue one access, check its sub-access pattern.
    task automatic do_acc(input logic we, input logic [1:0] sz, input logic [11:0] addr,
                          input logic [31:0] wd, input string tag);
        int off, cs, al, nbw, exp_n, base, step, waited;
        logic err;
        logic [31:0] ed;
        bit bad;
        off = int'(addr) & 32'h3FF;
        cs  = (sz == 2'd3) ? 4 : (1 << sz);
        al  = off & ~(cs - 1);
        nbw = map_width(off);
        err = (nbw == 0);
        ed  = '0;
        if (!err && !we) for (int k = 0; k < cs; k++) ed = {ed[23:0], shadow[al + k]};
        if (!err && we)  for (int k = 0; k < cs; k++) shadow[al + k] = wd[(cs - 1 - k) * 8 +: 8];
        if (err)              begin exp_n = 0; base = 0; step = 0; end
        else if (cs >= nbw)   begin exp_n = cs / nbw; base = al; step = nbw; end
        else                  begin exp_n = we ? 2 : 1; base = off & ~(nbw - 1); step = 0; end
        exp_d.push_back(ed); exp_e.push_back(err); exp_tag.push_back(tag);
        @(negedge clk);
        sub_n = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = addr; cpu_wdata = wd;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!cpu_ready && waited < 50);
        cpu_req = 1'b0;
        if (!cpu_ready) begin
            vectors++; miscompares++;
            $display("FAIL %s timeout: actual no ready expected ready", tag);
            void'(exp_d.pop_back()); void'(exp_e.pop_back()); void'(exp_tag.pop_back());
        end
        bad = (sub_n != exp_n);
        for (int i = 0; i < sub_n && i < exp_n; i++) begin
            if (sub_addr[i] != base + i * step || sub_sz[i] != nbw) bad = 1;
            if (cs < nbw && we && sub_we[i] != (i == 1)) bad = 1;
            if (!(cs < nbw && we) && sub_we[i] != we) bad = 1;
        end
        vectors++;
        if (bad) begin
            miscompares++;
            $display("FAIL %s sub-accesses: actual count=%0d first=%h expected count=%0d first=%h",
                     tag, sub_n, (sub_n > 0) ? sub_addr[0] : -1, exp_n, base);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual still running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            rf[i] = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        vectors++;
        if (cpu_ready !== 1'b0 || reg_req !== 1'b0 || cpu_err !== 1'b0) begin
            miscompares++;
            $display("FAIL R10 reset: actual ready=%b req=%b err=%b expected 0 0 0",
                     cpu_ready, reg_req, cpu_err);
        end
        rst_n = 1'b1;
        // R3: matching sizes
        do_acc(1'b0, 2'd2, 12'h040, 32'h0, "R3");
        do_acc(1'b1, 2'd2, 12'h044, 32'hA1B2C3D4, "R3");
        do_acc(1'b0, 2'd2, 12'h044, 32'h0, "R3");
        do_acc(1'b0, 2'd1, 12'h022, 32'h0, "R3");
        do_acc(1'b0, 2'd0, 12'h00B, 32'h0, "R3");
        // R4: byte of halfword register
        do_acc(1'b0, 2'd0, 12'h024, 32'h0, "R4");
        do_acc(1'b0, 2'd0, 12'h025, 32'h0, "R4");
        // R5: halfword of word register
        do_acc(1'b0, 2'd1, 12'h044, 32'h0, "R5");
        do_acc(1'b0, 2'd1, 12'h046, 32'h0, "R5");
        // R6: byte of word register, all lanes
        do_acc(1'b0, 2'd0, 12'h048, 32'h0, "R6");
        do_acc(1'b0, 2'd0, 12'h049, 32'h0, "R6");
        do_acc(1'b0, 2'd0, 12'h04A, 32'h0, "R6");
        do_acc(1'b0, 2'd0, 12'h04B, 32'h0, "R6");
        // R7: halfword to byte registers
        do_acc(1'b1, 2'd1, 12'h004, 32'h00005A6B, "R7");
        do_acc(1'b0, 2'd1, 12'h004, 32'h0, "R7");
        do_acc(1'b0, 2'd1, 12'h012, 32'h0, "R7");
        // R8: word to halfword and to byte registers
        do_acc(1'b0, 2'd2, 12'h030, 32'h0, "R8");
        do_acc(1'b1, 2'd2, 12'h034, 32'h11223344, "R8");
        do_acc(1'b0, 2'd2, 12'h034, 32'h0, "R8");
        do_acc(1'b1, 2'd2, 12'h008, 32'hCAFEF00D, "R8");
        do_acc(1'b0, 2'd2, 12'h008, 32'h0, "R8");
        // R9: narrow writes keep the other lanes
        do_acc(1'b1, 2'd0, 12'h027, 32'h000000E7, "R9");
        do_acc(1'b0, 2'd1, 12'h026, 32'h0, "R9");
        do_acc(1'b1, 2'd1, 12'h052, 32'h0000BEEF, "R9");
        do_acc(1'b0, 2'd2, 12'h050, 32'h0, "R9");
        do_acc(1'b1, 2'd0, 12'h05D, 32'h0000003C, "R9");
        do_acc(1'b1, 2'd0, 12'h05C, 32'h000000C3, "R9");
        do_acc(1'b0, 2'd2, 12'h05C, 32'h0, "R9");
        // R2: empty group, read and dropped write
        do_acc(1'b0, 2'd2, 12'h064, 32'h0, "R2");
        do_acc(1'b1, 2'd1, 12'h0E2, 32'h00001234, "R2");
        do_acc(1'b0, 2'd1, 12'h0A2, 32'h0, "R2");
        // R1: out-of-range and masked upper address bits
        do_acc(1'b1, 2'd2, 12'h204, 32'hDEADBEEF, "R1");
        do_acc(1'b0, 2'd2, 12'h3C4, 32'h0, "R1");
        do_acc(1'b0, 2'd1, 12'hC46, 32'h0, "R1");
        do_acc(1'b0, 2'd2, 12'h404, 32'h0, "R1");
        // R11: misaligned offsets and size code 3
        do_acc(1'b0, 2'd1, 12'h023, 32'h0, "R11");
        do_acc(1'b0, 2'd3, 12'h042, 32'h0, "R11");
        do_acc(1'b1, 2'd3, 12'h00F, 32'h01020304, "R11");
        do_acc(1'b0, 2'd2, 12'h00C, 32'h0, "R11");
        // R10: back-to-back completions already counted through the scoreboard
        repeat (4) @(negedge clk);
        vectors++;
        if (exp_d.size() != 0) begin
            miscompares++;
            $display("FAIL R10 pending: actual %0d outstanding expected 0", exp_d.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule